// File: doc/BRIEF.md
# Dual 16-bit Multiply-Accumulate Unit

This block takes two 32-bit operands and treats each one as a pair of signed 16-bit halves. It multiplies the low halves together and the high halves together. It then adds the two products or subtracts the second from the first. It can also add a 32-bit accumulator value to that sum or difference. The 32-bit result is registered and appears one cycle after the input strobe, with a matching valid flag.

Alongside the result the block keeps a sticky overflow flag. Only the sum form can set it. It is set when adding the two products overflows as a signed 32-bit addition. It is also set when adding the accumulator to that sum overflows. The result itself is never clamped: it always wraps modulo 2^32. The flag stays set until the clear input is raised.

Top module: `dmac16_unit`

## Requirements
- R1: With `sub_sel`=0 and `acc_en`=0, `res_out` equals (a[15:0]·b[15:0]) + (a[31:16]·b[31:16]). Both halves of each operand are read as signed two's-complement values.
- R2: With `sub_sel`=1 and `acc_en`=0, `res_out` equals (a[15:0]·b[15:0]) − (a[31:16]·b[31:16]), using the same signed halves.
- R3: With `acc_en`=1, `acc_in` is added to the sum or difference. With `acc_en`=0, `acc_in` has no effect on `res_out`.
- R4: `res_out` wraps modulo 2^32 on any overflow and is never clamped.
- R5: In the sum form (`sub_sel`=0), `q_flag` is set when adding the two products overflows as a signed 32-bit addition. This holds whether or not accumulation is enabled.
- R6: In the sum form with `acc_en`=1, `q_flag` is also set when adding `acc_in` to the product sum overflows as a signed 32-bit addition. Signed overflow means both addends have the same sign and the sum has the opposite sign.
- R7: The difference form (`sub_sel`=1) never sets `q_flag`, with or without accumulation.
- R8: `q_flag` is sticky and stays set until `q_clear` is high at a clock edge. If `q_clear` is high in the same cycle as a set condition, the flag ends up cleared.
- R9: An operation strobed by `in_valid` at edge k shows on `res_out` and raises `res_valid` after edge k. `res_valid` is high for exactly one cycle per strobe. `res_out` holds its value while no strobe arrives.
- R10: While `rst_n` is low, `res_out`, `res_valid` and `q_flag` are all 0.
- R11: When `in_valid` is 0, the operand inputs change neither `q_flag` nor `res_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: the operands on this cycle form one operation |
| op_a | input | 32 | First operand, two signed 16-bit halves |
| op_b | input | 32 | Second operand, two signed 16-bit halves |
| acc_in | input | 32 | Accumulator value |
| sub_sel | input | 1 | 0: sum of products, 1: difference of products |
| acc_en | input | 1 | 1: add `acc_in` to the sum or difference |
| q_clear | input | 1 | Clears the sticky overflow flag; takes priority over a set |
| res_out | output | 32 | Registered result |
| res_valid | output | 1 | High for one cycle when `res_out` is new |
| q_flag | output | 1 | Sticky signed-overflow flag |

## Verification
The product sum can overflow in only one case: both lanes multiply -32768 by -32768, which gives 0x40000000 twice. The stimulus therefore drives 0x80008000 on both operands. It runs this pattern in the sum form, in the sum form with an accumulator that pulls the total back into range, and in the difference form. Accumulation overflow is reached from both directions: a positive product sum with accumulator 0x7FFFFFFF, and a large negative product with accumulator 0x80000000. The stimulus also raises the clear in the same cycle as an overflowing operation, so that the priority between set and clear can be observed.

// File: rtl/dmac16_pkg.sv
package dmac16_pkg;

    typedef enum logic {
        OP_SUM  = 1'b0,
        OP_DIFF = 1'b1
    } dmac_op_e;

    // Signed add overflow: equal addend signs, different sum sign.
    function automatic logic add_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
        return (a_msb == b_msb) && (s_msb != a_msb);
    endfunction

endpackage

// File: rtl/dmac16_halfmul.sv
module dmac16_halfmul #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]   x_in,
    input  logic [HALF_W-1:0]   y_in,
    output logic [2*HALF_W-1:0] prod_out
);
    localparam int PROD_W = 2 * HALF_W;

    logic signed [PROD_W-1:0] x_ext;
    logic signed [PROD_W-1:0] y_ext;

    always_comb begin
        x_ext    = {{HALF_W{x_in[HALF_W-1]}}, x_in};
        y_ext    = {{HALF_W{y_in[HALF_W-1]}}, y_in};
        prod_out = x_ext * y_ext;
    end
endmodule

// File: rtl/dmac16_combine.sv
module dmac16_combine
    import dmac16_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] prod_lo,
    input  logic [DATA_W-1:0] prod_hi,
    input  logic [DATA_W-1:0] acc_val,
    input  dmac_op_e          op_sel,
    input  logic              acc_on,
    output logic [DATA_W-1:0] total_out,
    output logic              ovf_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] pair_d;
    logic              pair_ovf_d;
    logic              acc_ovf_d;

    always_comb begin
        if (op_sel == OP_DIFF) begin
            pair_d     = prod_lo - prod_hi;
            pair_ovf_d = 1'b0;
        end else begin
            pair_d     = prod_lo + prod_hi;
            pair_ovf_d = add_ovf(prod_lo[MSB], prod_hi[MSB], pair_d[MSB]);
        end

        total_out = acc_on ? (pair_d + acc_val) : pair_d;
        acc_ovf_d = acc_on && (op_sel == OP_SUM)
                    && add_ovf(pair_d[MSB], acc_val[MSB], total_out[MSB]);
        ovf_out   = pair_ovf_d | acc_ovf_d;
    end
endmodule

// File: rtl/dmac16_unit.sv
module dmac16_unit
    import dmac16_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic [2*HALF_W-1:0] acc_in,
    input  logic                sub_sel,
    input  logic                acc_en,
    input  logic                q_clear,
    output logic [2*HALF_W-1:0] res_out,
    output logic                res_valid,
    output logic                q_flag
);
    localparam int DATA_W = 2 * HALF_W;
    localparam int LANES  = 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              vld;
        logic              q;
    } st_t;

    st_t st_d, st_q;

    logic [DATA_W-1:0] prod_w [LANES];
    logic [DATA_W-1:0] comb_res_w;
    logic              comb_ovf_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmac16_halfmul #(.HALF_W(HALF_W)) u_mul (
            .x_in     (op_a[g*HALF_W +: HALF_W]),
            .y_in     (op_b[g*HALF_W +: HALF_W]),
            .prod_out (prod_w[g])
        );
    end

    dmac16_combine #(.DATA_W(DATA_W)) u_comb (
        .prod_lo   (prod_w[0]),
        .prod_hi   (prod_w[1]),
        .acc_val   (acc_in),
        .op_sel    (dmac_op_e'(sub_sel)),
        .acc_on    (acc_en),
        .total_out (comb_res_w),
        .ovf_out   (comb_ovf_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = comb_res_w;
            if (comb_ovf_w) st_d.q = 1'b1;
        end
        if (q_clear) st_d.q = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_out   = st_q.res;
    assign res_valid = st_q.vld;
    assign q_flag    = st_q.q;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_out));
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag && !q_clear) |=> q_flag);
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        q_clear |=> !q_flag);
    a_r7_diff_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_sel && !q_flag && !q_clear) |=> !q_flag);
    a_r11_idle_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !q_flag) |=> !q_flag);
    a_r5_ovf_sets_q: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && comb_ovf_w && !q_clear) |=> q_flag);
endmodule

// File: tb/dmac16_unit_bench.sv
`timescale 1ns/1ps
module dmac16_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] acc_in = '0;
    logic        sub_sel = 1'b0;
    logic        acc_en = 1'b0;
    logic        q_clear = 1'b0;
    logic [31:0] res_out;
    logic        res_valid;
    logic        q_flag;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    dmac16_unit u_dmac16_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .sub_sel(sub_sel), .acc_en(acc_en), .q_clear(q_clear),
        .res_out(res_out), .res_valid(res_valid), .q_flag(q_flag)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] acc;
        logic        sub;
        logic        acc_on;
        logic [31:0] exp_res;
        logic        exp_q;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0003_0002, 32'h0005_0004, 32'h0000_0000,   1'b0, 1'b0, 32'h0000_0017, 1'b0},
        '{32'hFFFF_0002, 32'h0005_FFFD, 32'h0000_0000,   1'b0, 1'b0, 32'hFFFF_FFF5, 1'b0},
        '{32'hFFFF_0002, 32'h0005_FFFD, 32'h0000_0000,   1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0},
        '{32'h0003_0002, 32'h0005_0004, 32'h0000_0100,   1'b0, 1'b1, 32'h0000_0117, 1'b0},
        '{32'h0003_0002, 32'h0005_0004, 32'h0000_0100,   1'b1, 1'b1, 32'h0000_00F9, 1'b0},
        '{32'h0003_0002, 32'h0005_0004, 32'h1234_5678,   1'b0, 1'b0, 32'h0000_0017, 1'b0},
        '{32'h8000_8000, 32'h8000_8000, 32'h0000_0000,   1'b0, 1'b0, 32'h8000_0000, 1'b1},
        '{32'h8000_8000, 32'h8000_8000, 32'h0000_0000,   1'b1, 1'b0, 32'h0000_0000, 1'b0},
        '{32'h0000_4000, 32'h0000_0002, 32'h7FFF_FFFF,   1'b0, 1'b1, 32'h8000_7FFF, 1'b1},
        '{32'h0000_4000, 32'h0000_0002, 32'h7FFF_FFFF,   1'b1, 1'b1, 32'h8000_7FFF, 1'b0},
        '{32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF,   1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000,   1'b0, 1'b1, 32'h4000_8000, 1'b1},
        '{32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h0000_0000,   1'b0, 1'b0, 32'h7FFE_0002, 1'b0}
    };

    function automatic string vec_tag(input int idx);
        case (idx)
            2:        return "R2";
            3, 4, 5:  return "R3";
            6, 10:    return "R5";
            7:        return "R7";
            8, 11:    return "R6";
            9:        return "R4";
            default:  return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
                         input logic sub, input logic acc_on, input logic clr);
        @(negedge clk);
        op_a = a; op_b = b; acc_in = acc; sub_sel = sub; acc_en = acc_on;
        in_valid = 1'b1; q_clear = clr;
        @(negedge clk);
        in_valid = 1'b0; q_clear = 1'b0;
    endtask

    task automatic clear_q();
        @(negedge clk);
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "res_out", res_out, 32'h0);
        chk("R10", "res_valid", {31'b0, res_valid}, 32'h0);
        chk("R10", "q_flag", {31'b0, q_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].a, VECS[i].b, VECS[i].acc, VECS[i].sub, VECS[i].acc_on, 1'b0);
            chk(vec_tag(i), "res_out", res_out, VECS[i].exp_res);
            chk(vec_tag(i), "q_flag", {31'b0, q_flag}, {31'b0, VECS[i].exp_q});
            chk("R9", "res_valid", {31'b0, res_valid}, 32'h1);
            clear_q();
        end

        // R9: valid is a single-cycle pulse and the result holds
        issue(32'h0003_0002, 32'h0005_0004, 32'h0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9", "res_valid after pulse", {31'b0, res_valid}, 32'h0);
        chk("R9", "res_out held", res_out, 32'h0000_0017);

        // R11: overflowing operands without a strobe do nothing
        @(negedge clk);
        op_a = 32'h8000_8000; op_b = 32'h8000_8000; sub_sel = 1'b0; acc_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11", "q_flag idle", {31'b0, q_flag}, 32'h0);
        chk("R11", "res_out idle", res_out, 32'h0000_0017);

        // R8: sticky across a non-overflowing operation
        issue(32'h8000_8000, 32'h8000_8000, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R8", "q set", {31'b0, q_flag}, 32'h1);
        issue(32'h0003_0002, 32'h0005_0004, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R8", "q sticky", {31'b0, q_flag}, 32'h1);
        chk("R8", "res after sticky", res_out, 32'h0000_0017);
        clear_q();
        chk("R8", "q cleared", {31'b0, q_flag}, 32'h0);

        // R8: clear in the same cycle as a set condition wins
        issue(32'h8000_8000, 32'h8000_8000, 32'h0, 1'b0, 1'b0, 1'b1);
        chk("R8", "clear priority", {31'b0, q_flag}, 32'h0);
        chk("R4", "wrapped result", res_out, 32'h8000_0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule